// File: doc/BRIEF.md
# Bitstream decimation FIR with table lookup

This block is the first decimating filter stage behind a one-bit oversampling modulator. Each clock it may accept one input bit, qualified by `in_valid`. A bit of 1 stands for +1 and a bit of 0 stands for -1. Every eighth accepted bit completes a group, and the block then emits one signed output word with a one-cycle `out_valid` pulse. The output rate is therefore one eighth of the accepted bit rate.

The 40-tap response is split into five segments of eight taps. Each segment owns a 256-entry table, built at elaboration from the coefficient parameter. The table holds the segment's signed partial sum for every possible 8-bit pattern. A five-group history selects the table entries, so the filter has no multipliers. Four adders then combine the five table outputs. The adder network is a linear chain or a pairwise tree, chosen by a parameter. The tree registers its first level, which costs one more cycle of latency.

The output sequencing is a small state machine. It starts in ST_ACCUM while bits are being collected. When a group completes it moves from ST_ACCUM to ST_SUM in the chain build, or from ST_ACCUM to ST_PIPE in the tree build. ST_PIPE always moves on to ST_SUM. ST_SUM is the one cycle in which `out_valid` is high, and it returns to ST_ACCUM. It would go back to ST_PIPE or ST_SUM only if another group completed in that same cycle, which cannot happen with eight-bit groups.

Top module: `bsdec_fir_top`

## Requirements
- R1: The output is the sum over i = 0..39 of c_i * x_i. Here x_i is +1 for an input bit of 1 and -1 for a bit of 0, i is the bit's age in accepted bits (0 = newest), and c_i is the signed field `COEFS[i*COEF_W +: COEF_W]`.
- R2: Exactly one output is produced per eight accepted bits. A cycle with `in_valid` low changes neither the bit count nor the history, whatever the value on `in_bit`.
- R3: `out_valid` is high for one cycle per output, and `out_data` changes only when `out_valid` rises.
- R4: With the eighth bit of a group sampled on clock edge E, `out_valid` and the new `out_data` appear after edge E+1 in the chain build (ADDER_TREE=0) and after edge E+2 in the tree build (ADDER_TREE=1).
- R5: The chain build and the tree build give identical output values for the same coefficients and input.
- R6: Reset (synchronous, active high) clears the bit count and drives `out_valid` and `out_data` to 0. It also fills the history with 0 bits, read as -1. Every later output matches a reference filter whose history starts as all -1.
- R7: `out_data` (COEF_W + clog2(40) + 1 bits) holds every possible result without wrapping. For all-1 input it equals the sum of c_i, and for all-0 input it equals minus that sum, including when every c_i is the most negative coefficient value.
- R8: The segment k table (k = 0..4) is indexed by the group that is k groups old. Bit j of that group drives tap k*8+j, and all 256 entries of every segment give the value R1 defines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_bit` this cycle |
| in_bit | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| out_valid | output | 1 | One-cycle pulse marking a new output word |
| out_data | output | OUT_W | Signed filter output, OUT_W = COEF_W + clog2(NSEG*SEG_LEN) + 1 |

## Verification
Each group's result is due one clock after the edge that samples its eighth bit in the chain build, and two clocks after it in the tree build. The bench records that due cycle when it drives the eighth bit and keeps it in a queue with the arithmetically computed value. It samples outputs on the falling edge and flags a late, early, missing or extra pulse as well as a wrong value. The sweep passes all 256 patterns through every history position, and it inserts idle cycles carrying junk bits to show they are ignored.

// File: rtl/bsdec_pkg.sv
package bsdec_pkg;

    typedef enum logic [1:0] {
        ST_ACCUM = 2'd0,
        ST_PIPE  = 2'd1,
        ST_SUM   = 2'd2
    } emit_state_e;

    localparam int DEF_COEF_W  = 12;
    localparam int DEF_SEG_LEN = 8;
    localparam int DEF_NSEG    = 5;
    localparam int DEF_TAPS    = DEF_SEG_LEN * DEF_NSEG;

    // Triangular default response, computed rather than listed.
    function automatic logic [DEF_TAPS*DEF_COEF_W-1:0] default_coefs();
        logic [DEF_TAPS*DEF_COEF_W-1:0] v;
        int tri_w;
        v = '0;
        for (int i = 0; i < DEF_TAPS; i++) begin
            tri_w = (i < DEF_TAPS/2) ? (i + 1) : (DEF_TAPS - i);
            v[i*DEF_COEF_W +: DEF_COEF_W] = DEF_COEF_W'(tri_w * 100 - 400);
        end
        return v;
    endfunction

endpackage

// File: rtl/bsdec_packer.sv
module bsdec_packer #(
    parameter int SEG_LEN = 8,
    parameter int NSEG    = 5,
    localparam int HIST_W = SEG_LEN * NSEG,
    localparam int CNT_W  = $clog2(SEG_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_bit,
    output logic [HIST_W-1:0] hist,
    output logic              grp_done
);

    logic [SEG_LEN-2:0] part_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               last_bit;

    assign last_bit = (cnt_q == CNT_W'(SEG_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q   <= '0;
            cnt_q    <= '0;
            hist     <= '0;
            grp_done <= 1'b0;
        end else begin
            grp_done <= in_valid && last_bit;
            if (in_valid) begin
                if (last_bit) begin
                    cnt_q  <= '0;
                    hist   <= {hist[HIST_W-SEG_LEN-1:0], part_q, in_bit};
                    part_q <= '0;
                end else begin
                    cnt_q  <= cnt_q + CNT_W'(1);
                    part_q <= {part_q[SEG_LEN-3:0], in_bit};
                end
            end
        end
    end

endmodule

// File: rtl/bsdec_seg_lut.sv
module bsdec_seg_lut #(
    parameter int COEF_W  = 12,
    parameter int SEG_LEN = 8,
    parameter int ENT_W   = 16,
    parameter logic [SEG_LEN*COEF_W-1:0] SEG_COEFS = '0,
    localparam int DEPTH  = 1 << SEG_LEN
) (
    input  logic [SEG_LEN-1:0]       idx,
    output logic signed [ENT_W-1:0]  part_sum
);

    function automatic logic [DEPTH*ENT_W-1:0] build_table();
        logic [DEPTH*ENT_W-1:0]  t;
        logic signed [ENT_W-1:0] acc;
        logic signed [COEF_W-1:0] c;
        t = '0;
        for (int p = 0; p < DEPTH; p++) begin
            acc = '0;
            for (int j = 0; j < SEG_LEN; j++) begin
                c = $signed(SEG_COEFS[j*COEF_W +: COEF_W]);
                if (p[j]) acc = acc + ENT_W'(c);
                else      acc = acc - ENT_W'(c);
            end
            t[p*ENT_W +: ENT_W] = acc;
        end
        return t;
    endfunction

    localparam logic [DEPTH*ENT_W-1:0] TBL = build_table();

    assign part_sum = $signed(TBL[int'(idx)*ENT_W +: ENT_W]);

endmodule

// File: rtl/bsdec_combiner.sv
module bsdec_combiner #(
    parameter int NSEG  = 5,
    parameter int ENT_W = 16,
    parameter int OUT_W = 19,
    parameter bit TREE  = 1'b0,
    localparam int NP   = (NSEG + 1) / 2,
    localparam int LVL2 = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    stage_en,
    input  logic [NSEG*ENT_W-1:0]   parts,
    output logic signed [OUT_W-1:0] total
);

    function automatic logic signed [OUT_W-1:0] ent(input int k);
        return OUT_W'($signed(parts[k*ENT_W +: ENT_W]));
    endfunction

    if (!TREE) begin : g_chain
        logic unused_ok;
        assign unused_ok = ^{clk, rst, stage_en};

        always_comb begin
            total = ent(0);
            for (int k = 1; k < NSEG; k++) begin
                total = total + ent(k);
            end
        end
    end else begin : g_tree
        logic signed [OUT_W-1:0] pr_q [NP];
        logic signed [OUT_W-1:0] w    [NP];
        int n;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < NP; i++) pr_q[i] <= '0;
            end else if (stage_en) begin
                for (int i = 0; i < NSEG/2; i++) pr_q[i] <= ent(2*i) + ent(2*i + 1);
                if (NSEG % 2 == 1) pr_q[NP-1] <= ent(NSEG - 1);
            end
        end

        always_comb begin
            for (int i = 0; i < NP; i++) w[i] = pr_q[i];
            n = NP;
            for (int lvl = 0; lvl < LVL2; lvl++) begin
                for (int i = 0; i < NP/2; i++) begin
                    if (i < n/2) w[i] = w[2*i] + w[2*i + 1];
                end
                if (n % 2 == 1) w[n/2] = w[n-1];
                n = (n + 1) / 2;
            end
            total = w[0];
        end
    end

endmodule

// File: rtl/bsdec_fir_top.sv
module bsdec_fir_top #(
    parameter int COEF_W     = bsdec_pkg::DEF_COEF_W,
    parameter int SEG_LEN    = bsdec_pkg::DEF_SEG_LEN,
    parameter int NSEG       = bsdec_pkg::DEF_NSEG,
    parameter bit ADDER_TREE = 1'b0,
    parameter logic [NSEG*SEG_LEN*COEF_W-1:0] COEFS = bsdec_pkg::default_coefs(),
    localparam int NTAPS     = NSEG * SEG_LEN,
    localparam int ENT_W     = COEF_W + $clog2(SEG_LEN) + 1,
    localparam int OUT_W     = COEF_W + $clog2(NTAPS) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_bit,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data
);
    import bsdec_pkg::*;

    logic [NTAPS-1:0]        hist;
    logic                    grp_done;
    logic [NSEG*ENT_W-1:0]   parts_w;
    logic signed [OUT_W-1:0] total;
    emit_state_e             state_q, state_d;

    bsdec_packer #(.SEG_LEN(SEG_LEN), .NSEG(NSEG)) u_packer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .hist     (hist),
        .grp_done (grp_done)
    );

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        bsdec_seg_lut #(
            .COEF_W    (COEF_W),
            .SEG_LEN   (SEG_LEN),
            .ENT_W     (ENT_W),
            .SEG_COEFS (COEFS[k*SEG_LEN*COEF_W +: SEG_LEN*COEF_W])
        ) u_lut (
            .idx      (hist[k*SEG_LEN +: SEG_LEN]),
            .part_sum (parts_w[k*ENT_W +: ENT_W])
        );
    end

    bsdec_combiner #(
        .NSEG  (NSEG),
        .ENT_W (ENT_W),
        .OUT_W (OUT_W),
        .TREE  (ADDER_TREE)
    ) u_comb (
        .clk      (clk),
        .rst      (rst),
        .stage_en (grp_done),
        .parts    (parts_w),
        .total    (total)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ACCUM;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM: if (grp_done) state_d = ADDER_TREE ? ST_PIPE : ST_SUM;
            ST_PIPE:  state_d = ST_SUM;
            ST_SUM:   state_d = grp_done ? (ADDER_TREE ? ST_PIPE : ST_SUM) : ST_ACCUM;
            default:  state_d = ST_ACCUM;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst)                  out_data <= '0;
        else if (state_d == ST_SUM) out_data <= total;
    end

    assign out_valid = (state_q == ST_SUM);

endmodule

// File: rtl/bsdec_chk.sv
module bsdec_chk #(
    parameter int COEF_W  = 12,
    parameter int SEG_LEN = 8,
    parameter int NTAPS   = 40,
    parameter int OUT_W   = 19,
    parameter bit TREE    = 1'b0,
    parameter logic [NTAPS*COEF_W-1:0] COEFS = '0,
    localparam int CNT_W  = $clog2(SEG_LEN)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    grp_done,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_data
);

    function automatic longint abs_total();
        longint s;
        longint c;
        s = 0;
        for (int i = 0; i < NTAPS; i++) begin
            c = longint'($signed(COEFS[i*COEF_W +: COEF_W]));
            s += (c < 0) ? -c : c;
        end
        return s;
    endfunction

    localparam longint SUM_ABS = abs_total();

    logic [CNT_W-1:0] seen_q;
    logic             eighth;

    assign eighth = in_valid && (seen_q == CNT_W'(SEG_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst)           seen_q <= '0;
        else if (eighth)   seen_q <= '0;
        else if (in_valid) seen_q <= seen_q + CNT_W'(1);
    end

    // R2
    grp_on_last_chk: assert property (@(posedge clk) disable iff (rst)
        eighth |=> grp_done);

    // R2
    grp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !eighth |=> !grp_done);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_data) |-> out_valid);

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'(out_data) <= SUM_ABS && longint'(out_data) >= -SUM_ABS));

    if (TREE) begin : g_lat_tree
        // R4
        lat_due_chk: assert property (@(posedge clk) disable iff (rst)
            grp_done |=> ##1 out_valid);
        // R4
        lat_cause_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> $past(grp_done, 2));
    end else begin : g_lat_chain
        // R4
        lat_due_chk: assert property (@(posedge clk) disable iff (rst)
            grp_done |=> out_valid);
        // R4
        lat_cause_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> $past(grp_done));
    end

endmodule

bind bsdec_fir_top bsdec_chk #(
    .COEF_W  (COEF_W),
    .SEG_LEN (SEG_LEN),
    .NTAPS   (NTAPS),
    .OUT_W   (OUT_W),
    .TREE    (ADDER_TREE),
    .COEFS   (COEFS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .grp_done  (grp_done),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/bsdec_fir_top_tb_top.sv
`timescale 1ns/1ps
module bsdec_fir_top_tb_top;

    localparam int CW    = 12;
    localparam int TAPS  = 40;
    localparam int OW    = 19;

    function automatic longint coef_a(input int i);
        return longint'((i * 731 + 97) % 4096) - 2048;
    endfunction

    function automatic logic [TAPS*CW-1:0] mk_a();
        logic [TAPS*CW-1:0] v;
        for (int i = 0; i < TAPS; i++) v[i*CW +: CW] = CW'(coef_a(i));
        return v;
    endfunction

    function automatic logic [TAPS*CW-1:0] mk_b();
        logic [TAPS*CW-1:0] v;
        for (int i = 0; i < TAPS; i++) v[i*CW +: CW] = CW'(-2048);
        return v;
    endfunction

    localparam logic [TAPS*CW-1:0] COEFS_A = mk_a();
    localparam logic [TAPS*CW-1:0] COEFS_B = mk_b();

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic ov [3];
    logic signed [OW-1:0] od0, od1, od2;

    always #2 clk = ~clk;

    bsdec_fir_top #(.ADDER_TREE(1'b0), .COEFS(COEFS_A)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .out_valid(ov[0]), .out_data(od0));
    bsdec_fir_top #(.ADDER_TREE(1'b1), .COEFS(COEFS_A)) dut_tree_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .out_valid(ov[1]), .out_data(od1));
    bsdec_fir_top #(.ADDER_TREE(1'b1), .COEFS(COEFS_B)) dut_ext_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
        .out_valid(ov[2]), .out_data(od2));

    int     cyc = 0;
    int     vectors = 0;
    int     fails = 0;
    bit     done = 1'b0;
    logic [TAPS-1:0] hb = '0;
    int     tcnt = 0;
    string  req = "R6";
    longint exp_q [3][$];
    int     due_q [3][$];
    int     lat [3] = '{1, 2, 2};

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint model(input int id);
        longint s;
        longint c;
        s = 0;
        for (int i = 0; i < TAPS; i++) begin
            c = (id == 2) ? -2048 : coef_a(i);
            s += hb[i] ? c : -c;
        end
        return s;
    endfunction

    function automatic longint od_of(input int id);
        case (id)
            0:       return longint'(od0);
            1:       return longint'(od1);
            default: return longint'(od2);
        endcase
    endfunction

    // Monitor: falling edge, compares against queued value and due cycle.
    always @(negedge clk) begin
        if (!rst) begin
            for (int id = 0; id < 3; id++) begin
                if (ov[id]) begin
                    vectors++;
                    if (exp_q[id].size() == 0) begin
                        fails++;
                        $display("FAIL R3 dut%0d extra pulse got data %0d exp no pulse", id, od_of(id));
                    end else begin
                        if (od_of(id) != exp_q[id][0]) begin
                            fails++;
                            $display("FAIL %s%s dut%0d data got %0d exp %0d", req,
                                     (id == 1) ? "/R5" : "", id, od_of(id), exp_q[id][0]);
                        end
                        if (cyc != due_q[id][0]) begin
                            fails++;
                            $display("FAIL R4 dut%0d pulse cycle got %0d exp %0d", id, cyc, due_q[id][0]);
                        end
                        void'(exp_q[id].pop_front());
                        void'(due_q[id].pop_front());
                    end
                end else if (due_q[id].size() != 0 && cyc >= due_q[id][0]) begin
                    vectors++;
                    fails++;
                    $display("FAIL R2 dut%0d missing output got none exp %0d at cycle %0d",
                             id, exp_q[id][0], due_q[id][0]);
                    void'(exp_q[id].pop_front());
                    void'(due_q[id].pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic send(input logic b, input logic v);
        @(negedge clk);
        in_valid = v;
        in_bit   = b;
        if (v) begin
            hb = {hb[TAPS-2:0], b};
            if (tcnt == 7) begin
                tcnt = 0;
                for (int id = 0; id < 3; id++) begin
                    exp_q[id].push_back(model(id));
                    due_q[id].push_back(cyc + 1 + lat[id]);
                end
            end else begin
                tcnt++;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) send(1'b0, 1'b0);
    endtask

    task automatic check_reset_state(input string tag);
        @(negedge clk);
        for (int id = 0; id < 3; id++) begin
            vectors++;
            if (ov[id] !== 1'b0 || od_of(id) != 0) begin
                fails++;
                $display("FAIL %s dut%0d reset state got valid=%0b data=%0d exp valid=0 data=0",
                         tag, id, ov[id], od_of(id));
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state("R6");
        hb = '0;
        tcnt = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        // R6: reset state, then first outputs against an all -1 history
        do_reset();
        req = "R6";
        for (int k = 0; k < 16; k++) send(k[0] ^ k[2], 1'b1);
        idle(4);

        // R8: every pattern passes through every segment position; R2 bubbles with junk bits
        req = "R8";
        for (int p = 0; p < 256; p++) begin
            for (int k = 7; k >= 0; k--) begin
                send(p[k], 1'b1);
                if (p % 3 == 0 && k == 4) send(~p[k], 1'b0);
            end
        end
        req = "R8";
        for (int p = 0; p < 256; p++) begin
            for (int k = 0; k < 8; k++) send(p[k] ^ p[(k + 3) % 8], 1'b1);
        end
        idle(4);

        // R7: extreme sums
        req = "R7";
        for (int k = 0; k < 48; k++) send(1'b1, 1'b1);
        for (int k = 0; k < 48; k++) send(1'b0, 1'b1);
        idle(4);

        // R1 and R2: pseudo-random bits with idle gaps carrying junk
        req = "R1/R2";
        for (int k = 0; k < 1200; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[0], lfsr[3] | lfsr[7]);
        end
        idle(6);

        // R6: reset mid-group clears the count and history
        for (int k = 0; k < 3; k++) send(1'b1, 1'b1);
        do_reset();
        req = "R6";
        for (int k = 0; k < 24; k++) send(k[1], 1'b1);
        idle(8);

        for (int id = 0; id < 3; id++) begin
            vectors++;
            if (exp_q[id].size() != 0) begin
                fails++;
                $display("FAIL R2 dut%0d pending outputs got %0d exp 0", id, exp_q[id].size());
            end
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got running exp finished");
            finish_run();
        end
    end

endmodule